// File: doc/BRIEF.md
# Local Interrupt Priority Controller

This block sits next to one processor core and decides when that core should be interrupted. It keeps three 256-bit vector arrays. The pending array records interrupts that have been requested. The servicing array records interrupts the core has taken but not yet retired. The trigger array records the trigger kind that came with each request. An 8-bit task priority register, written by software, sets a floor below which interrupts are held back.

Each array is split into 16 priority classes, using the upper four bits of the vector number. The block combines the task priority with the class of the highest vector in service to form a processor priority. It raises `intr` only when the best pending vector belongs to a strictly higher class than that priority.

The core takes an interrupt by pulsing `ack_req`. One cycle later the block answers with `ack_valid` and a vector number. If nothing was deliverable, the answer is a programmable spurious vector. The core retires an interrupt with an end-of-interrupt pulse.

Request pulses are always accepted, so there is no back-pressure on any input. Registers are read through a plain combinational read port.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, all three arrays and the task priority are zero, the spurious vector is 0xFF, and `intr` and `ack_valid` are low.
- R2: A cycle with `req_valid` high sets pending bit `req_vec` and writes `req_level` into trigger bit `req_vec`.
- R3: The best pending vector is the highest-numbered set bit, except that vector 2 wins whenever its bit is set. The best in-service vector is chosen by the same rule.
- R4: If the task priority's class (bits 7:4) is at least the class of the best in-service vector, the processor priority equals the task priority. Otherwise it equals that in-service class with a zero low nibble. With nothing in service, the in-service class counts as 0.
- R5: While `intr` is low, it rises one cycle after the class of the best pending vector becomes strictly greater than the processor priority's class. Once high, it stays high until an acknowledge, even if the priority rises.
- R6: A task priority write takes effect at once. Lowering it below a pending class raises `intr` in the following cycle.
- R7: An acknowledge with a deliverable vector clears that pending bit and sets its in-service bit. In the next cycle it returns the vector on `ack_vec` with `ack_valid` high, and `intr` is low.
- R8: An acknowledge with nothing deliverable returns the spurious vector and leaves the pending and in-service arrays unchanged. `intr` still drops.
- R9: An end-of-interrupt pulse clears the best in-service bit, chosen by the R3 rule. With no bit in service, it changes nothing.
- R10: The read port selects by `rd_sel`: 0 = pending, 1 = in-service, 2 = trigger, 3 = control. For the arrays, word `w` returns vectors 32w+31 down to 32w, so bit 0 of word 0 is vector 0. The control word returns {8'h00, spurious, processor priority, task priority}.
- R11: A `spur_we` pulse loads `spur_wdata` into the spurious vector register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request pulse, always accepted |
| req_vec | input | 8 | Vector being requested |
| req_level | input | 1 | Trigger kind stored with the request |
| ack_req | input | 1 | Core acknowledges the interrupt line |
| ack_valid | output | 1 | Acknowledge answer valid, one cycle after `ack_req` |
| ack_vec | output | 8 | Vector returned by the acknowledge |
| eoi | input | 1 | End-of-interrupt pulse |
| tpr_we | input | 1 | Task priority write strobe |
| tpr_wdata | input | 8 | Task priority write data |
| spur_we | input | 1 | Spurious vector write strobe |
| spur_wdata | input | 8 | Spurious vector write data |
| intr | output | 1 | Interrupt line to the core |
| rd_sel | input | 2 | Read select: pending, in-service, trigger, control |
| rd_word | input | 3 | 32-bit word index within the selected array |
| rd_data | output | 32 | Combinational read data |

## Verification
The embedded properties watch five things on every cycle:
- the processor priority never falls below the task priority's class;
- `intr` only rises after a deliverable vector was present;
- every acknowledge drops the line;
- a deliverable acknowledge leaves the returned vector in service;
- blocked acknowledges and empty end-of-interrupt pulses leave the arrays untouched.

Some behaviour only the bench scenarios can show. These are the exact vector picked by the high-to-low search, the precedence of vector 2 (which, being class 0, blocks every delivery while pending), nested servicing with the priority unwinding as each end-of-interrupt retires a vector, and the read-port word mapping.

// File: rtl/lipc_pkg.sv
package lipc_pkg;
  localparam int VW = 8;
  localparam int CW = 4;
  typedef enum logic [1:0] {
    RD_PEND = 2'd0,
    RD_SVC  = 2'd1,
    RD_TRIG = 2'd2,
    RD_CTL  = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/lipc_find.sv
module lipc_find
  import lipc_pkg::*;
#(
  parameter int N   = 256,
  parameter int HOT = 2
) (
  input  logic [N-1:0]  bits,
  output logic          any,
  output logic [VW-1:0] idx
);
  always_comb begin
    any = |bits;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (bits[i]) idx = VW'(i);
    end
    if (bits[HOT]) idx = VW'(HOT);
  end
endmodule

// File: rtl/lipc_gate.sv
module lipc_gate
  import lipc_pkg::*;
(
  input  logic [VW-1:0] tpr,
  input  logic          svc_any,
  input  logic [VW-1:0] svc_top,
  input  logic          pend_any,
  input  logic [VW-1:0] pend_top,
  output logic [VW-1:0] ppr,
  output logic          dlv
);
  logic [CW-1:0] svc_cls;
  always_comb begin
    svc_cls = svc_any ? svc_top[VW-1 -: CW] : '0;
    if (tpr[VW-1 -: CW] >= svc_cls) ppr = tpr;
    else                            ppr = {svc_cls, {(VW-CW){1'b0}}};
    dlv = pend_any && (pend_top[VW-1 -: CW] > ppr[VW-1 -: CW]);
  end
endmodule

// File: rtl/lipc_rdmux.sv
module lipc_rdmux
  import lipc_pkg::*;
#(
  parameter int N  = 256,
  parameter int DW = 32,
  parameter int NW = N / DW,
  parameter int WW = 3
) (
  input  logic [N-1:0]  pend,
  input  logic [N-1:0]  svc,
  input  logic [N-1:0]  trig,
  input  logic [DW-1:0] ctl,
  input  logic [1:0]    sel,
  input  logic [WW-1:0] word,
  output logic [DW-1:0] data
);
  logic [DW-1:0] pend_w [NW];
  logic [DW-1:0] svc_w  [NW];
  logic [DW-1:0] trig_w [NW];

  for (genvar g = 0; g < NW; g++) begin : g_word
    assign pend_w[g] = pend[g*DW +: DW];
    assign svc_w[g]  = svc[g*DW +: DW];
    assign trig_w[g] = trig[g*DW +: DW];
  end

  always_comb begin
    case (rd_sel_e'(sel))
      RD_PEND: data = pend_w[word];
      RD_SVC:  data = svc_w[word];
      RD_TRIG: data = trig_w[word];
      default: data = ctl;
    endcase
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import lipc_pkg::*;
#(
  parameter int DW      = 32,
  parameter int NMI_VEC = 2,
  localparam int NVEC   = 1 << VW,
  localparam int NW     = NVEC / DW,
  localparam int WW     = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [VW-1:0] req_vec,
  input  logic          req_level,
  input  logic          ack_req,
  output logic          ack_valid,
  output logic [VW-1:0] ack_vec,
  input  logic          eoi,
  input  logic          tpr_we,
  input  logic [VW-1:0] tpr_wdata,
  input  logic          spur_we,
  input  logic [VW-1:0] spur_wdata,
  output logic          intr,
  input  logic [1:0]    rd_sel,
  input  logic [WW-1:0] rd_word,
  output logic [DW-1:0] rd_data
);
  logic [NVEC-1:0] pend_q, svc_q, trig_q;
  logic [NVEC-1:0] pend_d, svc_d, trig_d;
  logic [VW-1:0]   tpr_q, spur_q, ppr;
  logic            pend_any, svc_any, dlv, take;
  logic [VW-1:0]   pend_top, svc_top;

  lipc_find #(.N(NVEC), .HOT(NMI_VEC)) u_pend_find (
    .bits(pend_q), .any(pend_any), .idx(pend_top));

  lipc_find #(.N(NVEC), .HOT(NMI_VEC)) u_svc_find (
    .bits(svc_q), .any(svc_any), .idx(svc_top));

  lipc_gate u_gate (
    .tpr(tpr_q), .svc_any(svc_any), .svc_top(svc_top),
    .pend_any(pend_any), .pend_top(pend_top), .ppr(ppr), .dlv(dlv));

  lipc_rdmux #(.N(NVEC), .DW(DW), .NW(NW), .WW(WW)) u_rd (
    .pend(pend_q), .svc(svc_q), .trig(trig_q),
    .ctl(DW'({spur_q, ppr, tpr_q})),
    .sel(rd_sel), .word(rd_word), .data(rd_data));

  assign take = ack_req && dlv;

  always_comb begin
    pend_d = pend_q;
    svc_d  = svc_q;
    trig_d = trig_q;
    if (take) pend_d[pend_top] = 1'b0;
    if (req_valid) begin
      pend_d[req_vec] = 1'b1;
      trig_d[req_vec] = req_level;
    end
    if (eoi && svc_any) svc_d[svc_top] = 1'b0;
    if (take) svc_d[pend_top] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= '0;
      svc_q     <= '0;
      trig_q    <= '0;
      tpr_q     <= '0;
      spur_q    <= '1;
      intr      <= 1'b0;
      ack_valid <= 1'b0;
      ack_vec   <= '0;
    end else begin
      pend_q    <= pend_d;
      svc_q     <= svc_d;
      trig_q    <= trig_d;
      ack_valid <= ack_req;
      if (tpr_we)  tpr_q  <= tpr_wdata;
      if (spur_we) spur_q <= spur_wdata;
      if (ack_req) ack_vec <= dlv ? pend_top : spur_q;
      if (ack_req)   intr <= 1'b0;
      else if (!intr) intr <= dlv;
    end
  end

  a_r4_ppr_floor: assert property (@(posedge clk) disable iff (!rst_n)
    ppr[VW-1 -: CW] >= tpr_q[VW-1 -: CW]);

  a_r5_rise_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intr) |-> $past(dlv));

  a_r7_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |=> !intr && ack_valid);

  a_r7_taken_in_service: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && dlv && !eoi) |=> svc_q[ack_vec]);

  a_r8_blocked_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !dlv && !req_valid && !eoi && !spur_we)
      |=> $stable(pend_q) && $stable(svc_q) && ack_vec == spur_q);

  a_r9_eoi_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !svc_any && !ack_req) |=> svc_q == '0);
endmodule

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_level = 0, ack_req = 0, eoi = 0;
  logic tpr_we = 0, spur_we = 0;
  logic [7:0] req_vec = 0, tpr_wdata = 0, spur_wdata = 0;
  logic [1:0] rd_sel = 0;
  logic [2:0] rd_word = 0;
  logic ack_valid, intr;
  logic [7:0] ack_vec;
  logic [31:0] rd_data;

  irq_prio_ctrl u0 (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [255:0] m_pend = 0, m_svc = 0, m_trig = 0;
  logic [7:0] m_tpr = 0, m_spur = 8'hFF, m_ackvec = 0;
  logic m_intr = 0, m_ackv = 0;

  function automatic int best(input logic [255:0] b);
    if (b[2]) return 2;
    for (int i = 255; i >= 0; i--) if (b[i]) return i;
    return -1;
  endfunction

  function automatic logic [7:0] m_ppr();
    int s = best(m_svc);
    int c = (s < 0) ? 0 : (s >> 4);
    if (int'(m_tpr[7:4]) >= c) return m_tpr;
    return 8'(c << 4);
  endfunction

  function automatic bit m_dlv();
    int p = best(m_pend);
    return (p >= 0) && ((p >> 4) > int'(m_ppr() >> 4));
  endfunction

  task automatic model_edge();
    bit d = m_dlv();
    int p = best(m_pend);
    int s = best(m_svc);
    logic [255:0] np = m_pend, ns = m_svc;
    if (ack_req && d) np[p] = 0;
    if (req_valid) begin np[req_vec] = 1; m_trig[req_vec] = req_level; end
    if (eoi && s >= 0) ns[s] = 0;
    if (ack_req && d) ns[p] = 1;
    if (ack_req) m_ackvec = d ? 8'(p) : m_spur;
    m_ackv = ack_req;
    if (ack_req) m_intr = 0; else if (!m_intr) m_intr = d;
    if (tpr_we) m_tpr = tpr_wdata;
    if (spur_we) m_spur = spur_wdata;
    m_pend = np; m_svc = ns;
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    req_valid = 0; ack_req = 0; eoi = 0; tpr_we = 0; spur_we = 0;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_intr(input string tag);
    chk(intr === m_intr, tag, 32'(intr), 32'(m_intr));
  endtask

  task automatic chk_rd(input int sel, input int w, input string tag);
    logic [31:0] e;
    rd_sel = 2'(sel); rd_word = 3'(w);
    #1;
    case (sel)
      0: e = m_pend[w*32 +: 32];
      1: e = m_svc[w*32 +: 32];
      2: e = m_trig[w*32 +: 32];
      default: e = {8'h00, m_spur, m_ppr(), m_tpr};
    endcase
    chk(rd_data === e, tag, rd_data, e);
  endtask

  task automatic do_req(input int v, input bit lvl);
    req_valid = 1; req_vec = 8'(v); req_level = lvl; cyc();
  endtask
  task automatic do_idle(); cyc(); endtask
  task automatic do_tpr(input int v); tpr_we = 1; tpr_wdata = 8'(v); cyc(); endtask
  task automatic do_eoi(); eoi = 1; cyc(); endtask
  task automatic do_ack(input string tag);
    ack_req = 1; cyc();
    chk(ack_valid === 1'b1, {tag, " ack_valid"}, 32'(ack_valid), 1);
    chk(ack_vec === m_ackvec, {tag, " ack_vec"}, 32'(ack_vec), 32'(m_ackvec));
    chk(intr === 1'b0, {tag, " intr dropped"}, 32'(intr), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(intr === 0, "R1 intr", 32'(intr), 0);
    chk(ack_valid === 0, "R1 ack_valid", 32'(ack_valid), 0);
    for (int s = 0; s < 3; s++)
      for (int w = 0; w < 8; w++) chk_rd(s, w, "R1 array zero");
    chk_rd(3, 0, "R1 control word");

    // R2 R3 R7 R9 R10: sweep every vector with class above zero
    for (int v = 16; v < 256; v++) begin
      do_req(v, v[0]);
      chk_rd(0, v / 32, "R2 R10 pending word");
      chk_rd(2, v / 32, "R2 trigger word");
      do_idle();
      chk_intr("R5 raise on pending");
      do_ack("R7 sweep");
      chk_rd(1, v / 32, "R7 in-service word");
      chk_rd(0, v / 32, "R7 pending cleared");
      do_eoi();
      chk_rd(1, v / 32, "R9 eoi clears");
    end

    // R3 search order: several pending, highest taken first
    do_req(40, 0); do_req(200, 0); do_req(130, 0); do_idle();
    do_ack("R3 highest first");
    do_ack("R3 next");
    chk_rd(3, 0, "R4 nested ppr");
    do_idle(); chk_intr("R5 blocked by service");
    do_eoi(); do_idle(); chk_intr("R9 unwind");
    do_ack("R3 next after eoi");
    do_eoi(); do_eoi(); do_idle(); chk_intr("R3 last");
    do_ack("R3 last ack"); do_eoi();

    // R4 R6 task priority sweep
    for (int c = 0; c < 16; c++) begin
      do_tpr(c * 16 + 5);
      chk_rd(3, 0, "R4 ppr equals tpr");
      do_req(8'h80, 1); do_idle();
      chk_intr("R5 tpr gate");
      do_ack("R8 tpr gate ack");
      if (m_svc != 0) do_eoi();
    end
    do_tpr(0); do_idle();
    chk_intr("R6 lowered tpr raises");
    do_ack("R6 ack"); do_eoi();

    // R4 nesting with tpr
    do_tpr(8'h30);
    do_req(8'h45, 0); do_idle(); do_ack("R4 take 45");
    chk_rd(3, 0, "R4 ppr from service class");
    do_req(8'h44, 0); do_idle(); chk_intr("R5 equal class blocked");
    do_req(8'h61, 0); do_idle(); do_ack("R4 take 61");
    do_tpr(8'h72); chk_rd(3, 0, "R4 tpr above service");
    do_tpr(8'h30);
    do_eoi(); chk_rd(3, 0, "R9 ppr after first eoi");
    do_eoi(); chk_rd(3, 0, "R9 ppr after second eoi");
    do_idle(); chk_intr("R5 44 released");
    do_ack("R7 take 44"); do_eoi(); do_tpr(0);

    // R5 sticky line
    do_req(8'h90, 0); do_idle(); chk_intr("R5 raised");
    do_tpr(8'hF0); do_idle(); chk_intr("R5 stays high after tpr raise");
    do_ack("R8 spurious while blocked");
    chk_rd(0, 4, "R8 pending kept");
    do_tpr(0); do_idle(); chk_intr("R6 re-raise");
    do_ack("R7 take 90"); do_eoi();

    // R9 empty eoi
    do_eoi();
    for (int w = 0; w < 8; w++) chk_rd(1, w, "R9 empty eoi no effect");
    chk_rd(3, 0, "R9 control unchanged");

    // R11 spurious register
    spur_we = 1; spur_wdata = 8'h3F; cyc();
    chk_rd(3, 0, "R11 spurious written");
    do_ack("R8 R11 nothing pending");

    // R3 vector 2 precedence, low classes never deliver
    do_req(8'h50, 0); do_req(2, 1); do_idle();
    chk_intr("R5 line raised before vector 2 seen");
    do_ack("R3 vector 2 blocks");
    chk_rd(0, 0, "R3 R10 vector 2 still pending");
    chk_rd(0, 2, "R3 vector 50 still pending");
    chk_rd(2, 0, "R2 trigger of vector 2");
    do_idle(); chk_intr("R3 blocked line stays low");
    for (int v = 0; v < 16; v++) begin
      do_req(v, 0); do_idle(); chk_intr("R5 class zero never raises");
    end
    chk_rd(0, 0, "R10 low word");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule